// File: doc/BRIEF.md
# Audio Noise Gate Controller

This block watches the level of a signed 16-bit audio sample stream and decides when the signal is too quiet to be worth passing. It keeps a peak level for the stream: the level jumps up to any larger sample magnitude and sinks slowly while the stream stays quiet. That level is compared with a threshold chosen by a 5-bit code. The code spans -76.5 dBFS to -30 dBFS in 1.5 dB steps, with full scale taken as 32767.

When the level falls below the threshold, the gate closes. It opens again only once the level clears the threshold by about 3 dB. A mode input selects what a closed gate does. In one mode it raises a flag that tells an external gain loop to keep its gain fixed, and the audio is untouched. In the other mode it replaces the outgoing samples with zero. An enable input switches the whole function off.

Top module: `audio_squelch`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `freeze_o`, `out_valid_o` and `out_sample_o` are 0, and the stored peak level is 0.
- R2: Code k selects the threshold magnitude round(32767 * 10^((1.5k - 76.5)/20)). Code 0 gives 5, code 11 gives 33 and code 31 gives 1036. With the gate enabled and open, a level strictly below the threshold closes the gate on the next clock edge.
- R3: A closed gate opens on the next clock edge once the level is strictly above the release magnitude. The release magnitude is floor(threshold * 45 / 32), which is 7 for code 0, 46 for code 11 and 1456 for code 31.
- R4: While the level is at or above the threshold and at or below the release magnitude, the gate keeps its state.
- R5: The level sample magnitude is the absolute value of the two's-complement input, with -32768 taken as 32767. A valid sample whose magnitude exceeds the stored level replaces that level.
- R6: Valid samples are counted modulo 32 from reset. On every 32nd valid sample that does not load a new magnitude, a nonzero level falls by max(level >> 8, 1). Without a valid sample the level does not change.
- R7: With `gate_en_i` low, the gate opens on the next edge and stays open. `freeze_o` is then 0 and samples pass unchanged.
- R8: With `gate_mode_i` = 0, `freeze_o` is 1 exactly while the gate is closed. Each valid sample appears unchanged on `out_sample_o` one cycle later.
- R9: With `gate_mode_i` = 1, `freeze_o` is 0. A valid sample presented while the gate is closed appears as 0 one cycle later, and one presented while the gate is open appears unchanged.
- R10: `out_valid_o` equals `in_valid_i` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| gate_en_i | input | 1 | 1 enables gating |
| gate_mode_i | input | 1 | 0 = hold gain, 1 = zero the output |
| thresh_code_i | input | 5 | Threshold code, 1.5 dB per step from -76.5 dBFS |
| in_valid_i | input | 1 | Input sample strobe |
| in_sample_i | input | 16 | Signed input sample |
| freeze_o | output | 1 | Tells the gain loop to hold its gain |
| out_valid_o | output | 1 | Output sample strobe |
| out_sample_o | output | 16 | Output sample, possibly zeroed |

## Verification
The vector walk feeds the gate magnitudes just below the threshold, inside the hysteresis band, exactly on the release magnitude and one above it. This tells a strict comparison apart from an inclusive one, and real hysteresis apart from a single threshold. Negative samples are mixed in, so a peak that ignores the sign bit would fail. The mode is switched between vectors, which separates hold behaviour from mute behaviour and shows that a sample is muted according to the gate state when it arrives. A long run of zero samples checks the decay period and the step size: the gate must stay open at a level equal to the threshold and close on the decay step that takes it one below.

// File: rtl/squelch_pkg.sv
// Package: shared widths and the threshold mapping for the noise gate.
// Assumes full scale 32767 and 1.5 dB per threshold code step.
package squelch_pkg;

    localparam int SAMPLE_W     = 16;
    localparam int LEVEL_W      = SAMPLE_W - 1;
    localparam int CODE_W       = 5;
    localparam int DECAY_LOG2   = 5;
    localparam int DECAY_SHIFT  = 8;
    localparam int REL_MUL      = 45;
    localparam int REL_SHIFT    = 5;

    // Linear magnitude of the threshold for one code: round(32767*10^(dB/20)).
    function automatic logic [LEVEL_W-1:0] open_level(input logic [CODE_W-1:0] code);
        logic [LEVEL_W-1:0] m;
        case (code)
            5'd0:  m = 15'd5;    5'd1:  m = 15'd6;    5'd2:  m = 15'd7;    5'd3:  m = 15'd8;
            5'd4:  m = 15'd10;   5'd5:  m = 15'd12;   5'd6:  m = 15'd14;   5'd7:  m = 15'd16;
            5'd8:  m = 15'd20;   5'd9:  m = 15'd23;   5'd10: m = 15'd28;   5'd11: m = 15'd33;
            5'd12: m = 15'd39;   5'd13: m = 15'd46;   5'd14: m = 15'd55;   5'd15: m = 15'd65;
            5'd16: m = 15'd78;   5'd17: m = 15'd92;   5'd18: m = 15'd110;  5'd19: m = 15'd130;
            5'd20: m = 15'd155;  5'd21: m = 15'd184;  5'd22: m = 15'd219;  5'd23: m = 15'd260;
            5'd24: m = 15'd309;  5'd25: m = 15'd368;  5'd26: m = 15'd437;  5'd27: m = 15'd519;
            5'd28: m = 15'd617;  5'd29: m = 15'd734;  5'd30: m = 15'd872;  default: m = 15'd1036;
        endcase
        return m;
    endfunction

    // Release magnitude roughly 3 dB above a threshold: floor(thr*45/32).
    function automatic logic [LEVEL_W-1:0] release_level(input logic [LEVEL_W-1:0] thr);
        logic [LEVEL_W+6:0] prod;
        prod = {7'd0, thr} * (LEVEL_W+7)'(REL_MUL);
        return LEVEL_W'(prod >> REL_SHIFT);
    endfunction

endpackage

// File: rtl/squelch_peak.sv
// Module: peak level tracker. Loads any larger sample magnitude and
// decays by level>>SHIFT (at least 1) once every 2**PERIOD_LOG2 valid
// samples. Assumes two's-complement samples; the most negative value
// saturates to the largest positive magnitude.
module squelch_peak #(
    parameter int SAMPLE_W    = 16,
    parameter int PERIOD_LOG2 = 5,
    parameter int SHIFT       = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_i,
    input  logic [SAMPLE_W-1:0]   sample_i,
    output logic [SAMPLE_W-2:0]   level_o
);
    localparam int LVL_W = SAMPLE_W - 1;
    localparam logic [PERIOD_LOG2-1:0] LAST = '1;

    logic [LVL_W-1:0]       level_q;
    logic [PERIOD_LOG2-1:0] count_q;
    logic [LVL_W-1:0]       mag;
    logic [LVL_W-1:0]       step;
    logic                   load;
    logic                   decay;

    // Purpose: absolute value of the sample, saturating the most negative code.
    always_comb begin
        logic [SAMPLE_W-1:0] neg;
        neg = -sample_i;
        if (!sample_i[SAMPLE_W-1])
            mag = sample_i[LVL_W-1:0];
        else if (neg[SAMPLE_W-1])
            mag = '1;
        else
            mag = neg[LVL_W-1:0];
    end

    // Purpose: decide between load, decay or hold and size the decay step.
    always_comb begin
        load  = valid_i && (mag > level_q);
        decay = valid_i && !load && (count_q == LAST) && (level_q != '0);
        step  = level_q >> SHIFT;
        if (step == '0)
            step = LVL_W'(1);
    end

    // Purpose: valid-sample counter that times the decay period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (valid_i)
            count_q <= count_q + 1'b1;
    end

    // Purpose: peak level register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= '0;
        else if (load)
            level_q <= mag;
        else if (decay)
            level_q <= level_q - step;
    end

    assign level_o = level_q;

    AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mag > level_q) |=> (level_o == $past(mag)));  // R5
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(level_o));  // R6
    AST_NO_RISE_ON_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mag <= level_q) |=> (level_o <= $past(level_o)));  // R6

endmodule

// File: rtl/squelch_hyst.sv
// Module: gate state with hysteresis. Closes when the level is below
// the coded threshold and opens when it exceeds the release magnitude.
// Assumes the level is already a non-negative magnitude.
module squelch_hyst
    import squelch_pkg::*;
#(
    parameter int LVL_W  = 15,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [LVL_W-1:0]  level_i,
    output logic              gated_o
);
    logic [LVL_W-1:0] thr;
    logic [LVL_W-1:0] rel;
    logic             gated_q;

    // Purpose: map the code to its close and release magnitudes.
    always_comb begin
        thr = LVL_W'(open_level(5'(code_i)));
        rel = LVL_W'(release_level(15'(thr)));
    end

    // Purpose: gate state register with hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gated_q <= 1'b0;
        else if (!enable_i)
            gated_q <= 1'b0;
        else if (!gated_q && level_i < thr)
            gated_q <= 1'b1;
        else if (gated_q && level_i > rel)
            gated_q <= 1'b0;
    end

    assign gated_o = gated_q;

    AST_DISABLED_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !gated_o);  // R7
    AST_CLOSE_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && level_i < thr) |=> gated_o);  // R2
    AST_OPEN_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && level_i > rel) |=> !gated_o);  // R3
    AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && level_i >= thr && level_i <= rel) |=> $stable(gated_o));  // R4

endmodule

// File: rtl/audio_squelch.sv
// Module: noise gate controller top. Tracks the input peak, keeps the
// gate state and applies it either as a freeze flag for an external
// gain loop or by zeroing the output samples.
// Assumes inputs are synchronous to clk; the output lags the input by one cycle.
module audio_squelch
    import squelch_pkg::*;
#(
    parameter int DATA_W   = SAMPLE_W,
    parameter int THR_W    = CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en_i,
    input  logic              gate_mode_i,
    input  logic [THR_W-1:0]  thresh_code_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_sample_i,
    output logic              freeze_o,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_sample_o
);
    localparam int LVL_W = DATA_W - 1;

    logic [LVL_W-1:0]  level;
    logic              gated;
    logic              out_valid_q;
    logic [DATA_W-1:0] out_sample_q;

    squelch_peak #(
        .SAMPLE_W    (DATA_W),
        .PERIOD_LOG2 (DECAY_LOG2),
        .SHIFT       (DECAY_SHIFT)
    ) u_peak (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (in_valid_i),
        .sample_i (in_sample_i),
        .level_o  (level)
    );

    squelch_hyst #(
        .LVL_W  (LVL_W),
        .CODE_W (THR_W)
    ) u_hyst (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (gate_en_i),
        .code_i   (thresh_code_i),
        .level_i  (level),
        .gated_o  (gated)
    );

    // Purpose: output sample stage, zeroing samples in mute mode while gated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q  <= 1'b0;
            out_sample_q <= '0;
        end else begin
            out_valid_q <= in_valid_i;
            if (in_valid_i)
                out_sample_q <= (gated && gate_mode_i) ? '0 : in_sample_i;
        end
    end

    assign freeze_o     = gated && !gate_mode_i;
    assign out_valid_o  = out_valid_q;
    assign out_sample_o = out_sample_q;

    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && gated && gate_mode_i) |=> (out_sample_o == '0));  // R9
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !(gated && gate_mode_i)) |=> (out_sample_o == $past(in_sample_i)));  // R8
    AST_VALID_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);  // R10
    AST_VALID_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);  // R10

endmodule

// File: tb/audio_squelch_test.sv
// Bench: walks a vector table through the gate, then directed tests
// for reset, disable and peak decay.
module audio_squelch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gate_en = 1'b0;
    logic        gate_mode = 1'b0;
    logic [4:0]  code = 5'd0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = 16'd0;
    logic        freeze;
    logic        out_valid;
    logic [15:0] out_sample;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    audio_squelch uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .gate_en_i     (gate_en),
        .gate_mode_i   (gate_mode),
        .thresh_code_i (code),
        .in_valid_i    (in_valid),
        .in_sample_i   (in_sample),
        .freeze_o      (freeze),
        .out_valid_o   (out_valid),
        .out_sample_o  (out_sample)
    );

    typedef struct packed {
        logic        mode;
        logic [4:0]  code;
        logic [15:0] sample;
        logic        exp_freeze;
        logic [15:0] exp_out;
    } vec_t;

    // Vectors walked after reset with the gate enabled and closed (level 0).
    localparam vec_t VECS [10] = '{
        '{1'b0, 5'd0,  16'd3,      1'b1, 16'd3},      // R2 3<5 stays closed
        '{1'b0, 5'd0,  16'hFFFA,   1'b1, 16'hFFFA},   // R4 level 6 in band
        '{1'b0, 5'd0,  16'd8,      1'b0, 16'd8},      // R3 8>7 opens
        '{1'b1, 5'd0,  16'hFFFC,   1'b0, 16'hFFFC},   // R9 open passes
        '{1'b1, 5'd31, 16'd1000,   1'b0, 16'd1000},   // R2 closes on code change
        '{1'b0, 5'd31, 16'd1200,   1'b1, 16'd1200},   // R8 freeze, data passes
        '{1'b1, 5'd31, 16'd1456,   1'b0, 16'd0},      // R4 on release, muted
        '{1'b1, 5'd31, 16'hFA4F,   1'b0, 16'd0},      // R5 R3 -1457 opens
        '{1'b0, 5'd31, 16'd500,    1'b0, 16'd500},    // R8 open, no freeze
        '{1'b1, 5'd31, 16'h8000,   1'b0, 16'h8000}    // R9 open, most negative
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one valid sample, return the output seen one cycle later.
    task automatic push(input logic m, input logic [4:0] c, input logic [15:0] s,
                        output logic [15:0] got, output logic gv);
        @(negedge clk);
        gate_mode = m;
        code      = c;
        in_valid  = 1'b1;
        in_sample = s;
        @(negedge clk);
        got = out_sample;
        gv  = out_valid;
        in_valid = 1'b0;
    endtask

    task automatic do_reset(input logic en, input logic m, input logic [4:0] c);
        @(negedge clk);
        rst_n = 1'b0;
        gate_en = en;
        gate_mode = m;
        code = c;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        logic        gv;

        // R1: reset state, with enable set so a missing reset would show.
        gate_en = 1'b1;
        repeat (3) @(negedge clk);
        check(freeze == 1'b0, "R1 freeze", int'(freeze), 0);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(out_sample == 16'd0, "R1 out_sample", int'(out_sample), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 first cycle valid", int'(out_valid), 0);
        check(freeze == 1'b1, "R2 level 0 closes", int'(freeze), 1);

        // Vector table walk: code 0, mode 0, gate already closed.
        for (int i = 0; i < 10; i++) begin
            push(VECS[i].mode, VECS[i].code, VECS[i].sample, got, gv);
            check(gv == 1'b1, "R10 out_valid", int'(gv), 1);
            check(got == VECS[i].exp_out, "R8/R9 out_sample", int'(got), int'(VECS[i].exp_out));
            @(negedge clk);
            check(freeze == VECS[i].exp_freeze, "R2/R3/R4 freeze", int'(freeze), int'(VECS[i].exp_freeze));
            check(out_valid == 1'b0, "R10 valid drops", int'(out_valid), 0);
        end

        // R7: disable opens a closed gate; samples pass.
        do_reset(1'b1, 1'b0, 5'd31);
        repeat (2) @(negedge clk);
        check(freeze == 1'b1, "R7 closed before disable", int'(freeze), 1);
        gate_en = 1'b0;
        @(negedge clk);
        check(freeze == 1'b0, "R7 opens on disable", int'(freeze), 0);
        push(1'b1, 5'd31, 16'd5, got, gv);
        check(got == 16'd5, "R7 mute mode passes", int'(got), 5);
        push(1'b0, 5'd31, 16'd7, got, gv);
        @(negedge clk);
        check(freeze == 1'b0, "R7 no freeze", int'(freeze), 0);

        // R6: decay from 47 with code 11 (thr 33, release 46).
        do_reset(1'b1, 1'b0, 5'd11);
        push(1'b0, 5'd11, 16'd47, got, gv);
        @(negedge clk);
        check(freeze == 1'b0, "R3 47>46 opens", int'(freeze), 0);
        for (int k = 2; k <= 479; k++)
            push(1'b0, 5'd11, 16'd0, got, gv);
        repeat (2) @(negedge clk);
        check(freeze == 1'b0, "R6 R2 level 33 stays open", int'(freeze), 0);
        push(1'b0, 5'd11, 16'd0, got, gv);
        @(negedge clk);
        check(freeze == 1'b1, "R6 15th decay closes", int'(freeze), 1);
        repeat (4) @(negedge clk);
        check(freeze == 1'b1, "R6 idle keeps level", int'(freeze), 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule